// File: doc/BRIEF.md
# S/T Interface Multiframe Bit Controller

This block sits in the network-side transmitter of a basic-rate S/T line and keeps track of where the current frame lies inside the 20-frame multiframe. Once per frame, on a single-cycle frame strobe, it decides the four overhead bits sent with the next frame:

- the auxiliary framing bit;
- its complement;
- the multiframe marker;
- one bit of the S channel, taken from an eight-bit parallel word.

In the receive direction it picks the Q-channel bits out of the auxiliary framing position of every fifth received frame. It delivers them as a nibble together with a one-cycle valid pulse.

Until the multiframe is declared aligned, the block does not produce its own framing pattern. It sends back whatever auxiliary framing bit it received last. A synchronize command switches it to generating the pattern. The switch takes effect at the next frame strobe, and the counter starts at frame 1. A loss-of-sync input returns it to echoing at the next frame strobe. Line coding, frame alignment and the B/D channels belong to other blocks.

Top module: `mframe_ctl`

## Requirements
- R1: `frame_no` counts frames 1 to 20. Each `frame_stb` advances it by one, and the count wraps from 20 to 1. After reset it reads 1.
- R2: In generate mode, `tx_fa` is 1 in frames 1, 6, 11 and 16 and 0 in every other frame.
- R3: `tx_n` is always the inverse of `tx_fa`.
- R4: `tx_m` is 1 only in frame 1 while generating, and 0 everywhere else, including in echo mode.
- R5: In generate mode, `tx_s` in frames 1, 2, 6, 7, 11, 12, 16 and 17 is `s_word[0]` through `s_word[7]`, in that order. In every other frame, and in echo mode, `tx_s` is 1.
- R6: In echo mode, each strobe sets `tx_fa` to the `rx_fa` value sampled with that strobe.
- R7: A `sync_cmd` pulse, given at or before a strobe, makes that strobe enter generate mode with `frame_no` = 1.
- R8: A `sync_lost` pulse, given at or before a strobe, makes that strobe enter echo mode. If both pulses are pending, loss wins.
- R9: While generating, the `rx_fa` value sampled at the strobe that ends frame 1, 6, 11 or 16 is Q1, Q2, Q3 or Q4. After the strobe that ends frame 16, `q_valid` is high for exactly one cycle, with `q_nib[0]`=Q1 through `q_nib[3]`=Q4. This happens only if frame 1 of the same multiframe was also collected while generating.
- R10: After reset the block is in echo mode, with `tx_fa`=0, `tx_n`=1, `tx_m`=0, `tx_s`=1, `q_valid`=0 and `q_nib`=4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse per frame boundary |
| rx_fa | input | 1 | Received auxiliary framing bit of the frame just ended |
| sync_cmd | input | 1 | Multiframe-aligned command pulse |
| sync_lost | input | 1 | Multiframe-alignment-lost pulse |
| s_word | input | 8 | S-channel bits, index 0 sent first |
| tx_fa | output | 1 | Auxiliary framing bit to send |
| tx_n | output | 1 | Complement bit to send |
| tx_m | output | 1 | Multiframe marker bit to send |
| tx_s | output | 1 | S-channel bit to send |
| frame_no | output | 5 | Current frame within the multiframe (1..20) |
| q_nib | output | 4 | Collected Q bits, Q1 in bit 0 |
| q_valid | output | 1 | One-cycle pulse when `q_nib` is updated |

## Verification
The hardest case to reach is a complete Q nibble. It needs a sync command, sixteen strobes in generate mode, and the right `rx_fa` values at exactly the four strobes that end frames 1, 6, 11 and 16. The stimulus issues the command between strobes and then drives a full 40-frame run. Throughout the run, a bench-side frame model decides which strobes carry Q data. A second run turns the sync command and the loss pulse on in the same strobe cycle, to show which one takes priority.

// File: rtl/mf_pkg.sv
package mf_pkg;
    typedef enum logic {
        MD_ECHO = 1'b0,
        MD_GEN  = 1'b1
    } mf_mode_e;
endpackage

// File: rtl/mf_position.sv
module mf_position
    import mf_pkg::*;
#(
    parameter int MF_LEN = 20,
    localparam int CW = $clog2(MF_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          sync_cmd,
    input  logic          sync_lost,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d_o,
    output logic          gen_q,
    output logic          gen_d_o
);
    typedef struct packed {
        mf_mode_e      mode;
        logic [CW-1:0] cnt;
        logic          sync_pend;
        logic          lost_pend;
    } pos_t;

    pos_t st_d, st_q;
    logic go_gen, go_echo;

    always_comb begin
        st_d    = st_q;
        go_gen  = sync_cmd  | st_q.sync_pend;
        go_echo = sync_lost | st_q.lost_pend;
        if (frame_stb) begin
            st_d.sync_pend = 1'b0;
            st_d.lost_pend = 1'b0;
            if (go_echo) begin
                st_d.mode = MD_ECHO;
                st_d.cnt  = (st_q.cnt == CW'(MF_LEN)) ? CW'(1) : st_q.cnt + CW'(1);
            end else if (go_gen) begin
                st_d.mode = MD_GEN;
                st_d.cnt  = CW'(1);
            end else begin
                st_d.cnt  = (st_q.cnt == CW'(MF_LEN)) ? CW'(1) : st_q.cnt + CW'(1);
            end
        end else begin
            st_d.sync_pend = go_gen;
            st_d.lost_pend = go_echo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_ECHO, cnt: CW'(1), sync_pend: 1'b0, lost_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q   = st_q.cnt;
    assign cnt_d_o = st_d.cnt;
    assign gen_q   = (st_q.mode == MD_GEN);
    assign gen_d_o = (st_d.mode == MD_GEN);

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && st_q.cnt == CW'(MF_LEN) && !go_gen) |=> (st_q.cnt == CW'(1)));

    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= CW'(1)) && (st_q.cnt <= CW'(MF_LEN)));

    p_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && go_gen && !go_echo) |=> (st_q.mode == MD_GEN && st_q.cnt == CW'(1)));

    p_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && go_echo) |=> (st_q.mode == MD_ECHO));
endmodule

// File: rtl/mf_txgen.sv
module mf_txgen #(
    parameter int MF_LEN   = 20,
    parameter int Q_STRIDE = 5,
    localparam int CW = $clog2(MF_LEN + 1),
    localparam int NQ = MF_LEN / Q_STRIDE,
    localparam int SN = 2 * NQ,
    localparam int SW = (SN > 1) ? $clog2(SN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          rx_fa,
    input  logic [CW-1:0] cnt_d,
    input  logic          gen_d,
    input  logic [SN-1:0] s_word,
    output logic          tx_fa,
    output logic          tx_n,
    output logic          tx_m,
    output logic          tx_s
);
    typedef struct packed {
        logic fa;
        logic n;
        logic m;
        logic s;
    } tx_t;

    tx_t tx_d, tx_q;
    int unsigned off, grp;
    logic [SW-1:0] sidx;

    always_comb begin
        tx_d = tx_q;
        off  = (int'(cnt_d) - 1) % Q_STRIDE;
        grp  = (int'(cnt_d) - 1) / Q_STRIDE;
        sidx = SW'(grp * 2 + off);
        if (frame_stb) begin
            if (gen_d) begin
                tx_d.fa = (off == 0);
                tx_d.m  = (cnt_d == CW'(1));
                tx_d.s  = (off < 2) ? s_word[sidx] : 1'b1;
            end else begin
                tx_d.fa = rx_fa;
                tx_d.m  = 1'b0;
                tx_d.s  = 1'b1;
            end
            tx_d.n = ~tx_d.fa;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '{fa: 1'b0, n: 1'b1, m: 1'b0, s: 1'b1};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_fa = tx_q.fa;
    assign tx_n  = tx_q.n;
    assign tx_m  = tx_q.m;
    assign tx_s  = tx_q.s;

    p_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.n != tx_q.fa);

    p_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !gen_d) |=> (tx_q.fa == $past(rx_fa)));

    p_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && gen_d && cnt_d == CW'(1)) |=> tx_q.m);
endmodule

// File: rtl/mf_qcollect.sv
module mf_qcollect #(
    parameter int MF_LEN   = 20,
    parameter int Q_STRIDE = 5,
    localparam int CW = $clog2(MF_LEN + 1),
    localparam int NQ = MF_LEN / Q_STRIDE,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          rx_fa,
    input  logic [CW-1:0] cnt_q,
    input  logic          gen_q,
    output logic [NQ-1:0] q_nib,
    output logic          q_valid
);
    typedef struct packed {
        logic [NQ-1:0] acc;
        logic          armed;
        logic [NQ-1:0] nib;
        logic          vld;
    } qc_t;

    qc_t qc_d, qc_q;
    int unsigned off, grp;
    logic [QW-1:0] qidx;

    always_comb begin
        qc_d     = qc_q;
        qc_d.vld = 1'b0;
        off  = (int'(cnt_q) - 1) % Q_STRIDE;
        grp  = (int'(cnt_q) - 1) / Q_STRIDE;
        qidx = QW'(grp);
        if (frame_stb) begin
            if (!gen_q) begin
                qc_d.armed = 1'b0;
            end else if (off == 0) begin
                qc_d.acc[qidx] = rx_fa;
                if (grp == 0) begin
                    qc_d.armed = 1'b1;
                end
                if (grp == NQ - 1) begin
                    if (qc_d.armed) begin
                        qc_d.nib = qc_d.acc;
                        qc_d.vld = 1'b1;
                    end
                    qc_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qc_q <= '{acc: '1, armed: 1'b0, nib: '1, vld: 1'b0};
        end else begin
            qc_q <= qc_d;
        end
    end

    assign q_nib   = qc_q.nib;
    assign q_valid = qc_q.vld;

    p_qpulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> !q_valid);

    p_qafter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> ($past(frame_stb) && $past(gen_q)));

    p_qhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> $stable(q_nib));
endmodule

// File: rtl/mframe_ctl.sv
module mframe_ctl
    import mf_pkg::*;
#(
    parameter int MF_LEN   = 20,
    parameter int Q_STRIDE = 5,
    localparam int CW = $clog2(MF_LEN + 1),
    localparam int NQ = MF_LEN / Q_STRIDE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic            rx_fa,
    input  logic            sync_cmd,
    input  logic            sync_lost,
    input  logic [2*NQ-1:0] s_word,
    output logic            tx_fa,
    output logic            tx_n,
    output logic            tx_m,
    output logic            tx_s,
    output logic [CW-1:0]   frame_no,
    output logic [NQ-1:0]   q_nib,
    output logic            q_valid
);
    logic [CW-1:0] cnt_q, cnt_d;
    logic          gen_q, gen_d;

    mf_position #(.MF_LEN(MF_LEN)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .sync_cmd  (sync_cmd),
        .sync_lost (sync_lost),
        .cnt_q     (cnt_q),
        .cnt_d_o   (cnt_d),
        .gen_q     (gen_q),
        .gen_d_o   (gen_d)
    );

    mf_txgen #(.MF_LEN(MF_LEN), .Q_STRIDE(Q_STRIDE)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .rx_fa     (rx_fa),
        .cnt_d     (cnt_d),
        .gen_d     (gen_d),
        .s_word    (s_word),
        .tx_fa     (tx_fa),
        .tx_n      (tx_n),
        .tx_m      (tx_m),
        .tx_s      (tx_s)
    );

    mf_qcollect #(.MF_LEN(MF_LEN), .Q_STRIDE(Q_STRIDE)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .rx_fa     (rx_fa),
        .cnt_q     (cnt_q),
        .gen_q     (gen_q),
        .q_nib     (q_nib),
        .q_valid   (q_valid)
    );

    assign frame_no = cnt_q;

    p_sonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_q || (((int'(cnt_q) - 1) % Q_STRIDE) > 1)) |-> tx_s);
endmodule

// File: tb/sim_mframe_ctl.sv
module sim_mframe_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       rx_fa = 1'b0;
    logic       sync_cmd = 1'b0;
    logic       sync_lost = 1'b0;
    logic [7:0] s_word = 8'h00;
    logic       tx_fa, tx_n, tx_m, tx_s, q_valid;
    logic [4:0] frame_no;
    logic [3:0] q_nib;

    int errors = 0;
    int checks = 0;
    int ef = 1;
    bit eg = 1'b0;
    bit pend_sync = 1'b0, pend_lost = 1'b0;
    bit [3:0] qacc = 4'hF;
    bit qarm = 1'b0;

    always #4 clk = ~clk;

    mframe_ctl u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_fa(rx_fa),
        .sync_cmd(sync_cmd), .sync_lost(sync_lost), .s_word(s_word),
        .tx_fa(tx_fa), .tx_n(tx_n), .tx_m(tx_m), .tx_s(tx_s),
        .frame_no(frame_no), .q_nib(q_nib), .q_valid(q_valid)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (frame %0d)", req, act, exp, ef);
        end
    endtask

    function automatic int s_pos(int f);
        case (f)
            1: return 0;   2: return 1;   6: return 2;   7: return 3;
            11: return 4;  12: return 5;  16: return 6;  17: return 7;
            default: return -1;
        endcase
    endfunction

    task automatic pulse(bit s, bit l);
        @(negedge clk);
        sync_cmd = s; sync_lost = l;
        @(negedge clk);
        sync_cmd = 1'b0; sync_lost = 1'b0;
        pend_sync |= s; pend_lost |= l;
    endtask

    // One frame strobe with optional commands, followed by a check of every output.
    task automatic strobe(bit rx, bit s, bit l);
        int done = ef;
        bit done_gen = eg;
        bit exp_v = 1'b0;
        bit [3:0] exp_nib = q_nib;
        @(negedge clk);
        frame_stb = 1'b1; rx_fa = rx; sync_cmd = s; sync_lost = l;
        @(negedge clk);
        frame_stb = 1'b0; sync_cmd = 1'b0; sync_lost = 1'b0;
        if (done_gen && (done == 1 || done == 6 || done == 11 || done == 16)) begin
            qacc[(done - 1) / 5] = rx;
            if (done == 1) qarm = 1'b1;
            if (done == 16) begin
                if (qarm) begin exp_v = 1'b1; exp_nib = qacc; end
                qarm = 1'b0;
            end
        end else if (!done_gen) begin
            qarm = 1'b0;
        end
        if (l || pend_lost) begin
            eg = 1'b0; ef = (ef == 20) ? 1 : ef + 1;
        end else if (s || pend_sync) begin
            eg = 1'b1; ef = 1;
        end else begin
            ef = (ef == 20) ? 1 : ef + 1;
        end
        pend_sync = 1'b0; pend_lost = 1'b0;
        check("R1 frame_no", frame_no, ef);
        if (eg) begin
            check("R2 tx_fa", tx_fa, (ef % 5 == 1) ? 1 : 0);
            check("R4 tx_m", tx_m, (ef == 1) ? 1 : 0);
            check("R5 tx_s", tx_s, (s_pos(ef) < 0) ? 1 : int'(s_word[s_pos(ef)]));
        end else begin
            check("R6 tx_fa echo", tx_fa, rx);
            check("R4 tx_m echo", tx_m, 0);
            check("R5 tx_s echo", tx_s, 1);
        end
        check("R3 tx_n", tx_n, !tx_fa);
        check("R9 q_valid", q_valid, exp_v);
        check("R9 q_nib", q_nib, exp_nib);
        @(negedge clk);
        check("R9 q_valid single", q_valid, 0);
    endtask

    task automatic t_reset();
        check("R10 tx_fa", tx_fa, 0);
        check("R10 tx_n", tx_n, 1);
        check("R10 tx_m", tx_m, 0);
        check("R10 tx_s", tx_s, 1);
        check("R10 q_valid", q_valid, 0);
        check("R10 q_nib", q_nib, 4'hF);
        check("R1 reset frame_no", frame_no, 1);
    endtask

    task automatic t_echo();
        bit [7:0] pat = 8'b1101_0010;
        for (int i = 0; i < 8; i++) strobe(pat[i], 1'b0, 1'b0);
    endtask

    task automatic t_generate(bit [7:0] sw, bit [3:0] q);
        s_word = sw;
        pulse(1'b1, 1'b0);                       // R7 command between strobes
        for (int i = 0; i < 40; i++) begin
            int f = ef;
            bit r = 1'b0;
            if (eg && f % 5 == 1) r = q[(f - 1) / 5];
            strobe(r, 1'b0, 1'b0);
        end
    endtask

    task automatic t_loss();
        pulse(1'b0, 1'b1);                       // R8 loss between strobes
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_sync_on_strobe();
        strobe(1'b0, 1'b1, 1'b0);                // R7 command with strobe
        check("R7 gen frame 1", frame_no, 1);
        for (int i = 0; i < 4; i++) strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b1, 1'b1, 1'b1);                // R8 loss beats sync
        strobe(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_echo();
        t_generate(8'b1001_0110, 4'b1011);
        t_loss();
        t_sync_on_strobe();
        t_generate(8'b0110_1001, 4'b0110);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule